// File: doc/BRIEF.md
# Privileged-access-never state bit controller

This block keeps the single processor-state flag that, when set, stops privileged code from touching user-accessible data. It owns that flag and applies three kinds of update to it. On an exception entry it decides, from the target exception level and a few control bits, whether to force the flag on or to keep the value that was saved for the entry. On an exception return it reloads the flag from the saved status word. On an immediate state-write instruction it loads the flag from bit 0 of the immediate. Only one update is applied per cycle, in a fixed priority order.

Alongside the flag it filters writes to the saved-status registers so that reserved bits read back as zero. It reports the feature in a 4-bit identification field. It also signals the outcome of each immediate write: a trap when the write comes from EL0, an undefined-instruction fault when the feature is absent, or, when the write is accepted, a one-cycle pulse that makes the data translation cache drop its cached control state. A single feature-enable input switches all of this off. Every output is registered, so each effect appears one clock after the cycle that caused it.

Top module: `pan_state_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero after that edge.
- R2: On an exception entry with the feature enabled and target level 1 (`entry_el` = 2'd1), the flag becomes 1 if `span_el1` is 0 and becomes `entry_saved_pan` if `span_el1` is 1.
- R3: On an exception entry with the feature enabled and target level 2 (`entry_el` = 2'd2), the flag is forced to 1 when `hcr_e2h`, `hcr_tge` are both 1 and `span_el2` is 0.
- R4: On an exception entry to level 2 that does not meet the R3 condition, or to level 3 (2'd3), the flag takes `entry_saved_pan`.
- R5: On an exception return with the feature enabled, the flag takes `ret_saved_pan` (bit 22 of the saved status word).
- R6: An immediate write with `imm_sel` equal to 4 (op1<<3|op2), from a level other than 0 and with the feature enabled, loads `imm_lsb` into the flag. One clock later `tlb_inval` is high for exactly one cycle.
- R7: An immediate write whose `imm_sel` is not 4 leaves the flag unchanged and raises none of `tlb_inval`, `imm_trap` or `imm_undef`.
- R8: An immediate write to the flag (selector 4) with `cur_el` = 2'd0 and the feature enabled raises `imm_trap` for one cycle, leaves the flag unchanged and raises no `tlb_inval`.
- R9: While `feat_en` is 0, the flag is cleared to 0 at every edge and ignores all events, and an immediate write with selector 4 raises `imm_undef` for one cycle.
- R10: A saved-status write (`spsr_wr`) presents `spsr_wdata` on `spsr_filt` one clock later, with `spsr_filt_vld` high for that cycle. Bits 23 and 21 are cleared when the feature is enabled. Bits 23, 22 and 21 are cleared when it is disabled. `spsr_filt` holds its value between writes.
- R11: When events coincide, exception entry wins over exception return, which wins over the immediate write. An immediate write that loses is discarded and raises none of `tlb_inval`, `imm_trap` or `imm_undef`.
- R12: `feat_field` reads 4'd1 while `feat_en` is 1 and 4'd0 while it is 0, and `status_view` is zero except for the flag at bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Feature present/enabled |
| exc_entry | input | 1 | Exception entry event this cycle |
| entry_el | input | 2 | Target exception level of the entry |
| entry_saved_pan | input | 1 | Flag value kept when entry does not force it |
| span_el1 | input | 1 | Level-1 system control: keep flag on entry when 1 |
| span_el2 | input | 1 | Level-2 system control: keep flag on entry when 1 |
| hcr_e2h | input | 1 | Hypervisor control: host-extension enable |
| hcr_tge | input | 1 | Hypervisor control: trap general exceptions |
| exc_return | input | 1 | Exception return event this cycle |
| ret_saved_pan | input | 1 | Bit 22 of the saved status word being restored |
| imm_wr | input | 1 | Immediate state-write instruction this cycle |
| imm_sel | input | 6 | Field selector op1<<3\|op2 of that instruction |
| imm_lsb | input | 1 | Bit 0 of the instruction immediate |
| cur_el | input | 2 | Exception level executing the immediate write |
| spsr_wr | input | 1 | Saved-status register write this cycle |
| spsr_wdata | input | 32 | Saved-status write data |
| pan_q | output | 1 | Current flag value |
| status_view | output | 32 | Status word view with the flag at bit 22 |
| feat_field | output | 4 | Identification field for the feature |
| tlb_inval | output | 1 | One-cycle invalidate request to the data translation cache |
| imm_undef | output | 1 | Undefined-instruction fault for the immediate write |
| imm_trap | output | 1 | Trap for an EL0 immediate write |
| spsr_filt | output | 32 | Filtered saved-status value |
| spsr_filt_vld | output | 1 | `spsr_filt` was written this cycle |

## Verification
The hardest situation to reach is two or three events in the same cycle, because a correct sequence of instructions never produces an exception entry, a return and an immediate write together. The bench drives these collisions on purpose, for example entry plus immediate write and return plus immediate write. It then runs a long pseudo-random phase in which every event line, level and control bit toggles on its own, so that priority and feature-off interactions occur many times. A behavioural model checks every output on every clock.

// File: rtl/pan_pkg.sv
package pan_pkg;
  typedef enum logic [1:0] {EL0 = 2'd0, EL1 = 2'd1, EL2 = 2'd2, EL3 = 2'd3} el_e;
  typedef enum logic [1:0] {SRC_HOLD, SRC_ENTRY, SRC_RETURN, SRC_IMM} pan_src_e;
  typedef struct packed {
    logic span_el1;
    logic span_el2;
    logic e2h;
    logic tge;
  } entry_ctl_t;
endpackage

// File: rtl/pan_entry_eval.sv
module pan_entry_eval
  import pan_pkg::*;
(
  input  el_e        tgt_el,
  input  entry_ctl_t ctl,
  input  logic       saved_pan,
  output logic       entry_pan
);
  logic force_set;

  always_comb begin
    unique case (tgt_el)
      EL1:     force_set = !ctl.span_el1;
      EL2:     force_set = ctl.e2h && ctl.tge && !ctl.span_el2;
      default: force_set = 1'b0;
    endcase
    entry_pan = force_set | saved_pan;
  end
endmodule

// File: rtl/pan_imm_decode.sv
module pan_imm_decode
  import pan_pkg::*;
#(
  parameter int SEL_W   = 6,
  parameter int PAN_SEL = 4
) (
  input  logic             feat_en,
  input  logic             imm_wr,
  input  logic             blocked,
  input  logic [SEL_W-1:0] imm_sel,
  input  el_e              cur_el,
  output logic             accept,
  output logic             trap,
  output logic             undef
);
  localparam logic [SEL_W-1:0] SEL_MATCH = SEL_W'(PAN_SEL);

  logic hit;

  always_comb begin
    hit    = imm_wr && !blocked && (imm_sel == SEL_MATCH);
    undef  = hit && !feat_en;
    trap   = hit && feat_en && (cur_el == EL0);
    accept = hit && feat_en && (cur_el != EL0);
  end
endmodule

// File: rtl/pan_spsr_filter.sv
module pan_spsr_filter #(
  parameter int DATA_W  = 32,
  parameter int PAN_POS = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feat_en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] filt,
  output logic              vld
);
  localparam int HI_POS = PAN_POS + 1;
  localparam int LO_POS = PAN_POS - 1;

  logic [DATA_W-1:0] keep_on;
  logic [DATA_W-1:0] keep_off;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep_on[i]  = !((i == HI_POS) || (i == LO_POS));
    assign keep_off[i] = !((i == HI_POS) || (i == LO_POS) || (i == PAN_POS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= wr;
      if (wr) filt <= wdata & (feat_en ? keep_on : keep_off);
    end
  end

  assert_reserved_clear_R10: assert property (@(posedge clk) disable iff (rst)
    vld |-> (!filt[HI_POS] && !filt[LO_POS]));

  assert_pan_clear_off_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && !feat_en) |=> !filt[PAN_POS]);
endmodule

// File: rtl/pan_state_ctrl.sv
module pan_state_ctrl
  import pan_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PAN_POS = 22,
  parameter int SEL_W   = 6,
  parameter int PAN_SEL = 4,
  parameter int FEAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feat_en,
  input  logic              exc_entry,
  input  logic [1:0]        entry_el,
  input  logic              entry_saved_pan,
  input  logic              span_el1,
  input  logic              span_el2,
  input  logic              hcr_e2h,
  input  logic              hcr_tge,
  input  logic              exc_return,
  input  logic              ret_saved_pan,
  input  logic              imm_wr,
  input  logic [SEL_W-1:0]  imm_sel,
  input  logic              imm_lsb,
  input  logic [1:0]        cur_el,
  input  logic              spsr_wr,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic              pan_q,
  output logic [DATA_W-1:0] status_view,
  output logic [FEAT_W-1:0] feat_field,
  output logic              tlb_inval,
  output logic              imm_undef,
  output logic              imm_trap,
  output logic [DATA_W-1:0] spsr_filt,
  output logic              spsr_filt_vld
);
  localparam logic [FEAT_W-1:0] FEAT_ON = FEAT_W'(1);

  entry_ctl_t ctl;
  logic       entry_pan;
  logic       imm_accept, imm_trap_c, imm_undef_c;
  pan_src_e   src;

  assign ctl = '{span_el1: span_el1, span_el2: span_el2, e2h: hcr_e2h, tge: hcr_tge};

  pan_entry_eval u_entry (
    .tgt_el    (el_e'(entry_el)),
    .ctl       (ctl),
    .saved_pan (entry_saved_pan),
    .entry_pan (entry_pan)
  );

  pan_imm_decode #(.SEL_W(SEL_W), .PAN_SEL(PAN_SEL)) u_imm (
    .feat_en (feat_en),
    .imm_wr  (imm_wr),
    .blocked (exc_entry | exc_return),
    .imm_sel (imm_sel),
    .cur_el  (el_e'(cur_el)),
    .accept  (imm_accept),
    .trap    (imm_trap_c),
    .undef   (imm_undef_c)
  );

  pan_spsr_filter #(.DATA_W(DATA_W), .PAN_POS(PAN_POS)) u_spsr (
    .clk     (clk),
    .rst     (rst),
    .feat_en (feat_en),
    .wr      (spsr_wr),
    .wdata   (spsr_wdata),
    .filt    (spsr_filt),
    .vld     (spsr_filt_vld)
  );

  always_comb begin
    if (exc_entry)       src = SRC_ENTRY;
    else if (exc_return) src = SRC_RETURN;
    else if (imm_accept) src = SRC_IMM;
    else                 src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pan_q      <= 1'b0;
      tlb_inval  <= 1'b0;
      imm_undef  <= 1'b0;
      imm_trap   <= 1'b0;
      feat_field <= '0;
    end else begin
      feat_field <= feat_en ? FEAT_ON : '0;
      tlb_inval  <= imm_accept;
      imm_undef  <= imm_undef_c;
      imm_trap   <= imm_trap_c;
      if (!feat_en) begin
        pan_q <= 1'b0;
      end else begin
        unique case (src)
          SRC_ENTRY:  pan_q <= entry_pan;
          SRC_RETURN: pan_q <= ret_saved_pan;
          SRC_IMM:    pan_q <= imm_lsb;
          default:    pan_q <= pan_q;
        endcase
      end
    end
  end

  always_comb begin
    status_view          = '0;
    status_view[PAN_POS] = pan_q;
  end

  assert_entry_el1_force_R2: assert property (@(posedge clk) disable iff (rst)
    (feat_en && exc_entry && entry_el == 2'd1 && !span_el1) |=> pan_q);

  assert_entry_el2_force_R3: assert property (@(posedge clk) disable iff (rst)
    (feat_en && exc_entry && entry_el == 2'd2 && hcr_e2h && hcr_tge && !span_el2) |=> pan_q);

  assert_entry_el3_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (feat_en && exc_entry && entry_el == 2'd3) |=> (pan_q == $past(entry_saved_pan)));

  assert_return_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (feat_en && !exc_entry && exc_return) |=> (pan_q == $past(ret_saved_pan)));

  assert_inval_cause_R6: assert property (@(posedge clk) disable iff (rst)
    tlb_inval |-> ($past(imm_wr) && $past(imm_sel) == SEL_W'(PAN_SEL)));

  assert_trap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    imm_trap |-> $stable(pan_q));

  assert_feat_off_R9: assert property (@(posedge clk) disable iff (rst)
    !feat_en |=> (!pan_q && !tlb_inval && !imm_trap));

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tlb_inval, imm_undef, imm_trap}));
endmodule

// File: tb/test_pan_state_ctrl.sv
module test_pan_state_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        feat_en, exc_entry, entry_saved_pan, span_el1, span_el2, hcr_e2h, hcr_tge;
  logic [1:0]  entry_el, cur_el;
  logic        exc_return, ret_saved_pan, imm_wr, imm_lsb, spsr_wr;
  logic [5:0]  imm_sel;
  logic [31:0] spsr_wdata;
  logic        pan_q, tlb_inval, imm_undef, imm_trap, spsr_filt_vld;
  logic [31:0] status_view, spsr_filt;
  logic [3:0]  feat_field;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  bit        m_pan, m_inval, m_undef, m_trap, m_vld;
  bit [3:0]  m_feat;
  bit [31:0] m_spsr;

  always #10 clk = ~clk;

  pan_state_ctrl i_pan_state_ctrl (
    .clk(clk), .rst(rst), .feat_en(feat_en), .exc_entry(exc_entry), .entry_el(entry_el),
    .entry_saved_pan(entry_saved_pan), .span_el1(span_el1), .span_el2(span_el2),
    .hcr_e2h(hcr_e2h), .hcr_tge(hcr_tge), .exc_return(exc_return),
    .ret_saved_pan(ret_saved_pan), .imm_wr(imm_wr), .imm_sel(imm_sel), .imm_lsb(imm_lsb),
    .cur_el(cur_el), .spsr_wr(spsr_wr), .spsr_wdata(spsr_wdata), .pan_q(pan_q),
    .status_view(status_view), .feat_field(feat_field), .tlb_inval(tlb_inval),
    .imm_undef(imm_undef), .imm_trap(imm_trap), .spsr_filt(spsr_filt),
    .spsr_filt_vld(spsr_filt_vld)
  );

  task automatic idle();
    exc_entry = 0; entry_el = 2'd1; entry_saved_pan = 0; span_el1 = 0; span_el2 = 0;
    hcr_e2h = 0; hcr_tge = 0; exc_return = 0; ret_saved_pan = 0; imm_wr = 0;
    imm_sel = 6'd0; imm_lsb = 0; cur_el = 2'd1; spsr_wr = 0; spsr_wdata = '0;
  endtask

  task automatic model_update();
    bit ent_force;
    if (rst) begin
      m_pan = 0; m_inval = 0; m_undef = 0; m_trap = 0; m_vld = 0; m_feat = 0; m_spsr = 0;
      return;
    end
    m_feat = feat_en ? 4'd1 : 4'd0;
    m_inval = 0; m_undef = 0; m_trap = 0;
    m_vld = spsr_wr;
    if (spsr_wr) m_spsr = spsr_wdata & (feat_en ? 32'hFF5F_FFFF : 32'hFF1F_FFFF);
    if (!feat_en) begin
      m_pan = 0;
      if (imm_wr && imm_sel == 6'd4 && !exc_entry && !exc_return) m_undef = 1;
    end else if (exc_entry) begin
      ent_force = (entry_el == 2'd1 && !span_el1) ||
                  (entry_el == 2'd2 && hcr_e2h && hcr_tge && !span_el2);
      m_pan = ent_force ? 1'b1 : entry_saved_pan;
    end else if (exc_return) begin
      m_pan = ret_saved_pan;
    end else if (imm_wr && imm_sel == 6'd4) begin
      if (cur_el == 2'd0) m_trap = 1;
      else begin m_pan = imm_lsb; m_inval = 1; end
    end
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    cmp(tag, "pan_q", 32'(pan_q), 32'(m_pan));
    cmp(tag, "tlb_inval", 32'(tlb_inval), 32'(m_inval));
    cmp(tag, "imm_undef", 32'(imm_undef), 32'(m_undef));
    cmp(tag, "imm_trap", 32'(imm_trap), 32'(m_trap));
    cmp(tag, "spsr_filt_vld", 32'(spsr_filt_vld), 32'(m_vld));
    cmp(tag, "spsr_filt", spsr_filt, m_spsr);
    cmp("R12", "feat_field", 32'(feat_field), 32'(m_feat));
    cmp("R12", "status_view", status_view, 32'(m_pan) << 22);
  endtask

  task automatic entry(logic [1:0] el, bit saved, string tag);
    idle(); exc_entry = 1; entry_el = el; entry_saved_pan = saved;
    step(tag); idle(); step(tag);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seed;
    idle(); feat_en = 1; rst = 1;
    step("R1"); step("R1");
    rst = 0; step("R12");
    // R2: level-1 entry
    span_el1 = 0; entry(2'd1, 0, "R2");
    idle(); exc_return = 1; ret_saved_pan = 0; step("R5");
    idle(); exc_entry = 1; entry_el = 2'd1; span_el1 = 1; step("R2");
    idle(); exc_entry = 1; entry_el = 2'd1; span_el1 = 1; entry_saved_pan = 1; step("R2");
    // R3 / R4: level-2 entry
    idle(); exc_return = 1; step("R5");
    idle(); exc_entry = 1; entry_el = 2'd2; hcr_e2h = 1; hcr_tge = 1; step("R3");
    idle(); exc_return = 1; step("R5");
    idle(); exc_entry = 1; entry_el = 2'd2; hcr_e2h = 1; hcr_tge = 0; step("R4");
    idle(); exc_entry = 1; entry_el = 2'd2; hcr_e2h = 1; hcr_tge = 1; span_el2 = 1; step("R4");
    idle(); exc_entry = 1; entry_el = 2'd3; entry_saved_pan = 1; step("R4");
    idle(); exc_entry = 1; entry_el = 2'd3; entry_saved_pan = 0; step("R4");
    // R5: return
    idle(); exc_return = 1; ret_saved_pan = 1; step("R5");
    // R6: immediate write
    idle(); imm_wr = 1; imm_sel = 6'd4; imm_lsb = 0; step("R6");
    idle(); step("R6");
    idle(); imm_wr = 1; imm_sel = 6'd4; imm_lsb = 1; step("R6");
    idle(); step("R6");
    // R7: other selector
    idle(); imm_wr = 1; imm_sel = 6'd5; imm_lsb = 0; step("R7");
    idle(); imm_wr = 1; imm_sel = 6'd3; imm_lsb = 0; step("R7");
    // R8: EL0 trap
    idle(); imm_wr = 1; imm_sel = 6'd4; imm_lsb = 0; cur_el = 2'd0; step("R8");
    idle(); step("R8");
    // R11: collisions
    idle(); exc_entry = 1; entry_el = 2'd3; imm_wr = 1; imm_sel = 6'd4; imm_lsb = 1; step("R11");
    idle(); exc_return = 1; ret_saved_pan = 1; imm_wr = 1; imm_sel = 6'd4; step("R11");
    idle(); exc_entry = 1; entry_el = 2'd3; exc_return = 1; ret_saved_pan = 1; step("R11");
    idle(); exc_return = 1; imm_wr = 1; imm_sel = 6'd4; cur_el = 2'd0; step("R11");
    // R10: saved-status filter
    idle(); spsr_wr = 1; spsr_wdata = 32'hFFFF_FFFF; step("R10");
    idle(); step("R10");
    idle(); feat_en = 0; spsr_wr = 1; spsr_wdata = 32'hFFFF_FFFF; step("R10");
    // R9: feature off
    idle(); feat_en = 1; imm_wr = 1; imm_sel = 6'd4; imm_lsb = 1; step("R9");
    idle(); feat_en = 0; step("R9");
    idle(); imm_wr = 1; imm_sel = 6'd4; imm_lsb = 1; step("R9");
    idle(); exc_entry = 1; entry_el = 2'd1; step("R9");
    idle(); exc_return = 1; ret_saved_pan = 1; step("R9");
    idle(); feat_en = 1; step("R12");
    // mixed pseudo-random phase for R11 and all interactions
    seed = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      seed = seed * 1103515245 + 12345;
      feat_en = (seed[20:17] != 0);
      exc_entry = seed[10] & seed[11];
      exc_return = seed[12] & seed[13];
      imm_wr = seed[14];
      imm_sel = seed[15] ? 6'd4 : {3'd0, seed[18:16]};
      imm_lsb = seed[19];
      cur_el = seed[22:21];
      entry_el = seed[24:23];
      entry_saved_pan = seed[25];
      span_el1 = seed[26]; span_el2 = seed[27];
      hcr_e2h = seed[28]; hcr_tge = seed[29];
      ret_saved_pan = seed[30];
      spsr_wr = seed[9];
      spsr_wdata = {seed[15:0], seed[31:16]};
      step("R11");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule